// File: doc/BRIEF.md
# Event-Driven PWM Counter and Waveform Generator

This block is a single pulse-width-modulation channel. A 16-bit counter, advanced by a 12-bit clock-enable divider, runs upward, downward or up-then-down between zero and a programmable period. Four counter events are detected: the counter sitting at zero, the counter sitting at the period value, a compare match while rising, and a compare match while falling. Each event carries its own 2-bit action that holds, clears, sets or toggles the waveform bit. Several actions combine into edge-aligned or centre-aligned waveforms without any fixed compare polarity.

The period and compare values are staged in shadow registers and only reach the active registers at a period boundary, so software may write them at any time without tearing a cycle. A single-cycle converter trigger pulse is raised on a selected event. At the end of the path, a mask override can replace the waveform with a fixed level, and an inverter flips the final pin. All configuration arrives on plain input ports.

Top module: `pwm_wavegen`

## Requirements
- R1: The counter advances only on a tick; with `enable` high a tick occurs once every `prescale`+1 clocks, and with `enable` low no tick occurs and the count holds.
- R2: In up mode (`cnt_mode`=0) the count runs 0,1,...,P and then returns to 0, where P is the active period.
- R3: In down mode (`cnt_mode`=1) the count runs P,P-1,...,0 and then reloads P.
- R4: In up-down mode (`cnt_mode`=2) the count rises 0..P and falls P..0, changing by exactly one per tick; the value P and the value 0 are each visited for one tick per turn-around.
- R5: A new `period_in`/`compare_in` becomes active only when the count moves to 0 (up and up-down modes) or reloads from 0 (down mode); the count never exceeds the active period.
- R6: While the active period is 0 the count stays at 0, no event fires, and the waveform does not change.
- R7: Each event applies its 2-bit action to the waveform bit on the tick where the count holds that event's value: 0 hold, 1 drive low, 2 drive high, 3 toggle.
- R8: When events coincide, only one action is applied: zero event first, then period event, then compare-up, then compare-down.
- R9: `adc_trig` is a one-clock pulse following a tick on the event chosen by `trig_sel`: 0 zero, 1 period, 2 zero or period, 3 compare while rising, 4 compare while falling; codes 5 to 7 never fire.
- R10: With `mask_en` high the pin shows `mask_level` instead of the waveform; the waveform keeps evolving underneath.
- R11: With `invert` high the pin is the complement of the masked-or-waveform value.
- R12: After reset the count is 0, the waveform bit is 0 and `adc_trig` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run enable for the tick divider |
| prescale | input | 12 | Tick divider; tick every prescale+1 clocks |
| cnt_mode | input | 2 | 0 up, 1 down, 2 up-down (3 behaves as up) |
| period_in | input | 16 | Period value, staged in a shadow register |
| compare_in | input | 16 | Compare value, staged in a shadow register |
| act_zero | input | 2 | Action at the zero event |
| act_period | input | 2 | Action at the period event |
| act_cmp_up | input | 2 | Action at compare match while rising |
| act_cmp_dn | input | 2 | Action at compare match while falling |
| trig_sel | input | 3 | Event that raises the converter trigger |
| mask_en | input | 1 | Replace waveform with mask_level |
| mask_level | input | 1 | Level shown while masked |
| invert | input | 1 | Invert the final pin |
| pwm_out | output | 1 | Channel output |
| adc_trig | output | 1 | One-clock converter trigger pulse |
| count_out | output | 16 | Current counter value |

## Verification
The assertions take the counting mode as fixed while the counter runs, since the one-step rule in up-down mode and the period bound only hold when `cnt_mode` is not switched mid-sweep. The stimulus changes the mode only while reset is asserted and starts each scenario from reset. Period and compare values, prescale, enable and the output controls change freely at falling clock edges, so the shadow-load timing and the enable gating are exercised mid-period.

// File: rtl/pwm_wavegen_pkg.sv
`timescale 1ns/1ps
package pwm_wavegen_pkg;

  typedef enum logic [1:0] {
    CM_UP     = 2'd0,
    CM_DOWN   = 2'd1,
    CM_UPDOWN = 2'd2,
    CM_RSVD   = 2'd3
  } cnt_mode_e;

  typedef enum logic [1:0] {
    ACT_HOLD   = 2'd0,
    ACT_LOW    = 2'd1,
    ACT_HIGH   = 2'd2,
    ACT_TOGGLE = 2'd3
  } wave_act_e;

  typedef enum logic [2:0] {
    TRG_ZERO     = 3'd0,
    TRG_PERIOD   = 3'd1,
    TRG_ZERO_PRD = 3'd2,
    TRG_CMP_UP   = 3'd3,
    TRG_CMP_DN   = 3'd4,
    TRG_NONE5    = 3'd5,
    TRG_NONE6    = 3'd6,
    TRG_NONE7    = 3'd7
  } trig_sel_e;

  typedef struct packed {
    logic zero;
    logic period;
    logic cmp_up;
    logic cmp_dn;
  } cnt_events_t;

endpackage

// File: rtl/pwm_wg_prescaler.sv
`timescale 1ns/1ps
// Clock-enable divider: one tick every div+1 clocks while run is high (R1).
module pwm_wg_prescaler #(
  parameter int PSC_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PSC_W-1:0] div,
  output logic             tick
);
  localparam logic [PSC_W-1:0] PSC_ONE = PSC_W'(1);

  logic [PSC_W-1:0] psc_q, psc_d;

  always_comb begin
    tick  = run && (psc_q >= div);
    psc_d = psc_q;
    if (!run)      psc_d = '0;
    else if (tick) psc_d = '0;
    else           psc_d = psc_q + PSC_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) psc_q <= '0;
    else        psc_q <= psc_d;
  end
endmodule

// File: rtl/pwm_wg_counter.sv
`timescale 1ns/1ps
// Mode-selectable counter with shadowed period/compare and event detection.
module pwm_wg_counter
  import pwm_wavegen_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  cnt_mode_e        mode,
  input  logic [CNT_W-1:0] per_shadow,
  input  logic [CNT_W-1:0] cmp_shadow,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] act_per,
  output cnt_events_t      ev
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] per_q, per_d;
  logic [CNT_W-1:0] cmp_q, cmp_d;
  logic             dir_q, dir_d;
  logic             rising;
  logic             running;
  logic             load;

  // Direction used for compare events
  always_comb begin
    unique case (mode)
      CM_DOWN:   rising = 1'b0;
      CM_UPDOWN: rising = dir_q;
      default:   rising = 1'b1;
    endcase
  end

  assign running = (per_q != '0);

  always_comb begin
    ev.zero   = tick && running && (cnt_q == '0);
    ev.period = tick && running && (cnt_q == per_q);
    ev.cmp_up = tick && running && rising  && (cnt_q == cmp_q);
    ev.cmp_dn = tick && running && !rising && (cnt_q == cmp_q);
  end

  // Next-state: count sequence per mode (R2, R3, R4), stall at period 0 (R6)
  always_comb begin
    cnt_d = cnt_q;
    dir_d = dir_q;
    load  = 1'b0;
    if (tick) begin
      if (!running) begin
        cnt_d = '0;
        dir_d = 1'b1;
        load  = 1'b1;
      end else begin
        unique case (mode)
          CM_DOWN: begin
            if (cnt_q == '0) begin
              cnt_d = per_shadow;
              load  = 1'b1;
            end else begin
              cnt_d = cnt_q - CNT_ONE;
            end
          end
          CM_UPDOWN: begin
            if (dir_q) begin
              if (cnt_q >= per_q) begin
                dir_d = 1'b0;
                cnt_d = per_q - CNT_ONE;
              end else begin
                cnt_d = cnt_q + CNT_ONE;
              end
            end else if (cnt_q == '0) begin
              dir_d = 1'b1;
              cnt_d = CNT_ONE;
            end else begin
              cnt_d = cnt_q - CNT_ONE;
            end
            load = (cnt_d == '0);
          end
          default: begin
            if (cnt_q >= per_q) cnt_d = '0;
            else                cnt_d = cnt_q + CNT_ONE;
            load = (cnt_d == '0);
          end
        endcase
      end
    end
  end

  // Shadow transfer only at the period boundary (R5)
  always_comb begin
    per_d = per_q;
    cmp_d = cmp_q;
    if (load) begin
      per_d = per_shadow;
      cmp_d = cmp_shadow;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= 1'b1;
      per_q <= '0;
      cmp_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
      per_q <= per_d;
      cmp_q <= cmp_d;
    end
  end

  assign cnt     = cnt_q;
  assign act_per = per_q;
endmodule

// File: rtl/pwm_wg_output.sv
`timescale 1ns/1ps
// Event-action waveform, converter trigger, mask and polarity stage.
module pwm_wg_output
  import pwm_wavegen_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  cnt_events_t ev,
  input  wave_act_e   a_zero,
  input  wave_act_e   a_period,
  input  wave_act_e   a_cmp_up,
  input  wave_act_e   a_cmp_dn,
  input  trig_sel_e   tsel,
  input  logic        mask_en,
  input  logic        mask_level,
  input  logic        invert,
  output logic        pin,
  output logic        trig
);
  logic      wave_q, wave_d;
  logic      trig_q, trig_d;
  wave_act_e act;

  // One action per clock, zero > period > compare-up > compare-down (R8)
  always_comb begin
    if (ev.zero)        act = a_zero;
    else if (ev.period) act = a_period;
    else if (ev.cmp_up) act = a_cmp_up;
    else if (ev.cmp_dn) act = a_cmp_dn;
    else                act = ACT_HOLD;
  end

  // Action encoding (R7)
  always_comb begin
    unique case (act)
      ACT_LOW:    wave_d = 1'b0;
      ACT_HIGH:   wave_d = 1'b1;
      ACT_TOGGLE: wave_d = ~wave_q;
      default:    wave_d = wave_q;
    endcase
  end

  // Trigger event select (R9)
  always_comb begin
    unique case (tsel)
      TRG_ZERO:     trig_d = ev.zero;
      TRG_PERIOD:   trig_d = ev.period;
      TRG_ZERO_PRD: trig_d = ev.zero | ev.period;
      TRG_CMP_UP:   trig_d = ev.cmp_up;
      TRG_CMP_DN:   trig_d = ev.cmp_dn;
      default:      trig_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wave_q <= 1'b0;
      trig_q <= 1'b0;
    end else begin
      wave_q <= wave_d;
      trig_q <= trig_d;
    end
  end

  // Mask first, polarity last (R10, R11)
  assign pin  = (mask_en ? mask_level : wave_q) ^ invert;
  assign trig = trig_q;
endmodule

// File: rtl/pwm_wavegen.sv
`timescale 1ns/1ps
module pwm_wavegen
  import pwm_wavegen_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PSC_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [PSC_W-1:0] prescale,
  input  logic [1:0]       cnt_mode,
  input  logic [CNT_W-1:0] period_in,
  input  logic [CNT_W-1:0] compare_in,
  input  logic [1:0]       act_zero,
  input  logic [1:0]       act_period,
  input  logic [1:0]       act_cmp_up,
  input  logic [1:0]       act_cmp_dn,
  input  logic [2:0]       trig_sel,
  input  logic             mask_en,
  input  logic             mask_level,
  input  logic             invert,
  output logic             pwm_out,
  output logic             adc_trig,
  output logic [CNT_W-1:0] count_out
);
  // Reset: asserted asynchronously, released through a synchronizer
  logic [SYNC_STAGES-1:0] rst_pipe_q;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[SYNC_STAGES-1];

  logic             tick;
  logic [CNT_W-1:0] act_per;
  cnt_events_t      ev;

  pwm_wg_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run   (enable),
    .div   (prescale),
    .tick  (tick)
  );

  pwm_wg_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .tick       (tick),
    .mode       (cnt_mode_e'(cnt_mode)),
    .per_shadow (period_in),
    .cmp_shadow (compare_in),
    .cnt        (count_out),
    .act_per    (act_per),
    .ev         (ev)
  );

  pwm_wg_output u_out (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .ev         (ev),
    .a_zero     (wave_act_e'(act_zero)),
    .a_period   (wave_act_e'(act_period)),
    .a_cmp_up   (wave_act_e'(act_cmp_up)),
    .a_cmp_dn   (wave_act_e'(act_cmp_dn)),
    .tsel       (trig_sel_e'(trig_sel)),
    .mask_en    (mask_en),
    .mask_level (mask_level),
    .invert     (invert),
    .pin        (pwm_out),
    .trig       (adc_trig)
  );
endmodule

// File: rtl/pwm_wavegen_chk.sv
`timescale 1ns/1ps
module pwm_wavegen_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic [1:0]       mode,
  input logic [CNT_W-1:0] act_per,
  input logic [CNT_W-1:0] count_out,
  input logic             adc_trig
);
  localparam logic [CNT_W-1:0] C_ONE = CNT_W'(1);

  p_hold_no_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count_out));

  p_updown_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == 2'd2 && act_per != '0) |=>
      (count_out == $past(count_out) + C_ONE || count_out == $past(count_out) - C_ONE));

  p_within_period_r5: assert property (@(posedge clk) disable iff (!rst_n)
    count_out <= act_per);

  p_stall_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && act_per == '0) |=> (count_out == '0));

  p_trig_after_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    adc_trig |-> $past(tick));
endmodule

bind pwm_wavegen pwm_wavegen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .tick      (tick),
  .mode      (cnt_mode),
  .act_per   (act_per),
  .count_out (count_out),
  .adc_trig  (adc_trig)
);

// File: tb/pwm_wavegen_tb_top.sv
`timescale 1ns/1ps
module pwm_wavegen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        en;
  logic [11:0] psc;
  logic [1:0]  mode;
  logic [15:0] per_in, cmp_in;
  logic [1:0]  az, ap, acu, acd;
  logic [2:0]  tsel;
  logic        msk_en, msk_lvl, inv;
  logic        pwm_out, adc_trig;
  logic [15:0] count_out;

  always #2.5 clk = ~clk;

  pwm_wavegen dut_i (
    .clk(clk), .rst_n(rst_n), .enable(en), .prescale(psc), .cnt_mode(mode),
    .period_in(per_in), .compare_in(cmp_in), .act_zero(az), .act_period(ap),
    .act_cmp_up(acu), .act_cmp_dn(acd), .trig_sel(tsel), .mask_en(msk_en),
    .mask_level(msk_lvl), .invert(inv), .pwm_out(pwm_out), .adc_trig(adc_trig),
    .count_out(count_out)
  );

  typedef struct packed {
    logic [15:0] cnt;
    logic        out;
    logic        trig;
  } exp_t;

  exp_t  sb_q[$];
  int    n_checks = 0;
  int    n_errors = 0;
  bit    done = 0;
  string tag_cnt = "R12", tag_out = "R12", tag_trig = "R12";

  // Reference state, derived from the requirement text
  logic [11:0] m_psc;
  logic [15:0] m_cnt, m_per, m_cmp;
  logic        m_up, m_wave, m_trig;

  task automatic check(input string req, input int act, input int exp_v);
    n_checks++;
    if (act != exp_v) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp_v, $time);
    end
  endtask

  task automatic model_reset();
    m_psc = '0; m_cnt = '0; m_per = '0; m_cmp = '0;
    m_up = 1'b1; m_wave = 1'b0; m_trig = 1'b0;
  endtask

  task automatic model_step();
    logic tk, up, ez, ep, ecu, ecd;
    logic [1:0] a;
    tk = en && (m_psc >= psc);
    if (!en || tk) m_psc = '0; else m_psc = m_psc + 12'd1;
    m_trig = 1'b0;
    if (tk) begin
      if (m_per == 16'd0) begin
        m_cnt = '0; m_up = 1'b1; m_per = per_in; m_cmp = cmp_in;
      end else begin
        up  = (mode == 2'd1) ? 1'b0 : (mode == 2'd2) ? m_up : 1'b1;
        ez  = (m_cnt == 16'd0);
        ep  = (m_cnt == m_per);
        ecu = up && (m_cnt == m_cmp);
        ecd = !up && (m_cnt == m_cmp);
        a = ez ? az : ep ? ap : ecu ? acu : ecd ? acd : 2'd0;
        if (a == 2'd1) m_wave = 1'b0;
        else if (a == 2'd2) m_wave = 1'b1;
        else if (a == 2'd3) m_wave = ~m_wave;
        case (tsel)
          3'd0: m_trig = ez;
          3'd1: m_trig = ep;
          3'd2: m_trig = ez | ep;
          3'd3: m_trig = ecu;
          3'd4: m_trig = ecd;
          default: m_trig = 1'b0;
        endcase
        if (mode == 2'd1) begin
          if (ez) begin m_cnt = per_in; m_per = per_in; m_cmp = cmp_in; end
          else m_cnt = m_cnt - 16'd1;
        end else begin
          if (mode == 2'd2) begin
            if (m_up) begin
              if (ep) begin m_up = 1'b0; m_cnt = m_per - 16'd1; end
              else m_cnt = m_cnt + 16'd1;
            end else if (ez) begin m_up = 1'b1; m_cnt = 16'd1; end
            else m_cnt = m_cnt - 16'd1;
          end else begin
            if (ep) m_cnt = '0; else m_cnt = m_cnt + 16'd1;
          end
          if (m_cnt == 16'd0) begin m_per = per_in; m_cmp = cmp_in; end
        end
      end
    end
  endtask

  // Driver: computes the value expected after the coming rising edge
  task automatic drive(input int n);
    exp_t e;
    for (int i = 0; i < n; i++) begin
      model_step();
      e.cnt  = m_cnt;
      e.out  = (msk_en ? msk_lvl : m_wave) ^ inv;
      e.trig = m_trig;
      sb_q.push_back(e);
      @(negedge clk);
    end
  endtask

  // Monitor: compares just after each rising edge
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        check(tag_cnt,  count_out, e.cnt);
        check(tag_out,  pwm_out,   e.out);
        check(tag_trig, adc_trig,  e.trig);
      end
    end
  end

  task automatic restart(input logic [1:0] md);
    @(negedge clk);
    rst_n = 1'b0; en = 1'b0; mode = md;
    msk_en = 1'b0; msk_lvl = 1'b0; inv = 1'b0;
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic set_acts(input logic [1:0] z, input logic [1:0] p,
                          input logic [1:0] u, input logic [1:0] d);
    az = z; ap = p; acu = u; acd = d;
  endtask

  initial begin
    rst_n = 1'b0; en = 1'b0; psc = '0; mode = '0; per_in = '0; cmp_in = '0;
    set_acts(0, 0, 0, 0); tsel = 3'd7; msk_en = 0; msk_lvl = 0; inv = 0;

    // R12: reset state
    restart(2'd0);
    check("R12", count_out, 0);
    check("R12", pwm_out, 0);
    check("R12", adc_trig, 0);

    // R2/R7/R9: up mode, zero sets high, compare-up drives low, trigger on zero
    restart(2'd0);
    tag_cnt = "R2"; tag_out = "R7"; tag_trig = "R9";
    psc = 0; per_in = 16'd5; cmp_in = 16'd2; set_acts(2, 0, 1, 0); tsel = 3'd0; en = 1;
    drive(30);

    // R1: prescaler of 2 and an enable gap
    restart(2'd0);
    tag_cnt = "R1"; tag_out = "R7"; tag_trig = "R9";
    psc = 12'd2; per_in = 16'd3; cmp_in = 16'd1; set_acts(3, 0, 0, 0); tsel = 3'd1; en = 1;
    drive(25);
    en = 0; drive(7);
    en = 1; psc = 12'd0; drive(10);

    // R3/R9: down mode, period drives low, compare-down high, trigger on compare-down
    restart(2'd1);
    tag_cnt = "R3"; tag_out = "R7"; tag_trig = "R9";
    psc = 0; per_in = 16'd4; cmp_in = 16'd1; set_acts(0, 1, 0, 2); tsel = 3'd4; en = 1;
    drive(30);

    // R4/R9: up-down centre aligned, trigger on zero or period
    restart(2'd2);
    tag_cnt = "R4"; tag_out = "R7"; tag_trig = "R9";
    psc = 0; per_in = 16'd4; cmp_in = 16'd2; set_acts(0, 0, 2, 1); tsel = 3'd2; en = 1;
    drive(40);
    tsel = 3'd3; drive(20);

    // R5: shadow update mid-period in up mode and in up-down mode
    restart(2'd0);
    tag_cnt = "R5"; tag_out = "R5"; tag_trig = "R9";
    psc = 0; per_in = 16'd6; cmp_in = 16'd3; set_acts(2, 0, 1, 0); tsel = 3'd3; en = 1;
    drive(10);
    per_in = 16'd2; cmp_in = 16'd1; drive(15);
    restart(2'd2);
    per_in = 16'd5; cmp_in = 16'd2; set_acts(3, 0, 2, 1); en = 1;
    drive(8);
    per_in = 16'd3; cmp_in = 16'd1; drive(20);
    restart(2'd1);
    per_in = 16'd5; cmp_in = 16'd2; set_acts(0, 2, 0, 1); en = 1;
    drive(4);
    per_in = 16'd2; drive(14);

    // R6: zero period stalls the counter with no events
    restart(2'd0);
    tag_cnt = "R6"; tag_out = "R6"; tag_trig = "R6";
    psc = 0; per_in = 16'd0; cmp_in = 16'd0; set_acts(3, 3, 3, 3); tsel = 3'd2; en = 1;
    drive(12);
    check("R6", count_out, 0);
    check("R6", pwm_out, 0);
    per_in = 16'd2; drive(8);

    // R8: compare coinciding with zero (compare action ignored) and with period
    restart(2'd0);
    tag_cnt = "R2"; tag_out = "R8"; tag_trig = "R9";
    psc = 0; per_in = 16'd4; cmp_in = 16'd0; set_acts(0, 0, 2, 0); tsel = 3'd3; en = 1;
    drive(15);
    check("R8", pwm_out, 0);
    cmp_in = 16'd4; set_acts(2, 1, 3, 0); drive(15);

    // R9: unused trigger codes never fire
    tag_trig = "R9"; tsel = 3'd6; drive(10);

    // R10/R11: mask override and polarity while the waveform keeps running
    restart(2'd0);
    tag_cnt = "R2"; tag_out = "R10"; tag_trig = "R9";
    psc = 12'd1; per_in = 16'd3; cmp_in = 16'd2; set_acts(2, 0, 1, 0); tsel = 3'd0; en = 1;
    drive(8);
    msk_en = 1; msk_lvl = 1; drive(8);
    check("R10", pwm_out, 1);
    msk_lvl = 0; drive(6);
    check("R10", pwm_out, 0);
    tag_out = "R11"; inv = 1; drive(6);
    check("R11", pwm_out, 1);
    msk_en = 0; drive(12);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule